// File: doc/BRIEF.md
# Dual-Buffer Packet Memory Controller

This block owns two byte-wide packet buffers of 2048 bytes each. One holds a frame waiting to go out and the other holds a frame that has come in. A host reaches them through a small byte-wide register port. A mux bit in the mode register selects which buffer sits behind the host data port, and the network side uses the other one. A host pointer addresses the data port and moves forward by one after every data access, so a frame can be streamed with back-to-back accesses after the pointer is loaded once.

Three command flags in the mode register start an operation: a transmit, a receive arm or a DMA transfer. Each flag sets itself when the host writes a 1 to it, stays set while the operation is busy, and clears itself when the matching completion strobe arrives from the network engine or the DMA model. When the receive completes, the length of the frame is latched and can be read back at the pointer offsets. A write to the abort offset cancels a DMA in progress.

Top module: `pktmem_ctrl`

## Requirements
- R1: After reset the transmit, receive and DMA flags are 0, the mux bit is 0 (transmit buffer on the host side), the host pointer is 0 and the received byte count is 0.
- R2: A host write to offset 0 loads pointer bits 7:0, and a write to offset 1 loads pointer bits 10:8 from data bits 2:0. Offset 4 is the data port: a write stores host_wdata in the host-facing buffer at the pointer, and a read returns the byte stored there.
- R3: Each host read or write at offset 4 advances the pointer by one. Pointer value 2047 wraps to 0.
- R4: Mode bit 0 is the mux bit, written by every mode write (offset 2). When it is 1 the receive buffer faces the host, and when it is 0 the transmit buffer does. Host data writes change only the buffer facing the host.
- R5: A mode write with bit 5 set raises tx_go. The flag holds until a tx_fin pulse, and it reads 0 in the cycle after that pulse.
- R6: A mode write with bit 6 set raises rx_open. An rx_fin pulse while rx_open is 1 latches rx_len as the received byte count and drops rx_open. An rx_fin pulse while rx_open is 0 leaves the count unchanged.
- R7: A mode write with bit 7 set raises dma_go. The flag is cleared by a dma_fin pulse or by any host write to offset 3.
- R8: Writing 0 to a command bit in a mode write leaves that flag as it was. Mode bits 4:1 are ignored and read back as 0.
- R9: A read of offset 3 returns rx_open in bit 5, tx_go in bit 4 and dma_go in bit 3, with all other bits 0. A read of offset 2 returns dma_go in bit 7, rx_open in bit 6, tx_go in bit 5 and the mux bit in bit 0, with bits 4:1 at 0.
- R10: Host reads of offset 0 and offset 1 return bits 7:0 and bits 11:8 of the received byte count, and they do not move the pointer.
- R11: A network write (rx_wr) lands in the receive buffer only while rx_open is 1 and the mux bit is 0. Otherwise it is ignored.
- R12: tx_rd_data returns the transmit buffer byte at tx_rd_addr in the same cycle, whatever the mux setting.
- R13: When a mode write sets a command bit in the same cycle as that flag's completion strobe, the set wins and the flag stays 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| host_addr | input | 3 | Host register offset |
| host_wr | input | 1 | Host write strobe |
| host_rd | input | 1 | Host read strobe (needed only for data-port reads) |
| host_wdata | input | 8 | Host write data |
| host_rdata | output | 8 | Host read data for the current offset |
| tx_go | output | 1 | Transmit requested or busy |
| tx_fin | input | 1 | Transmit completion pulse |
| tx_rd_addr | input | 11 | Network read address into the transmit buffer |
| tx_rd_data | output | 8 | Transmit buffer byte at tx_rd_addr |
| rx_open | output | 1 | Receive armed |
| rx_wr | input | 1 | Network write strobe into the receive buffer |
| rx_wr_addr | input | 11 | Network write address |
| rx_wr_data | input | 8 | Network write data |
| rx_fin | input | 1 | Frame received pulse |
| rx_len | input | 12 | Length of the received frame, sampled with rx_fin |
| dma_go | output | 1 | DMA requested or busy |
| dma_fin | input | 1 | DMA completion pulse |

## Verification
The collision that matters is a host mode write that sets a command bit in the same cycle as that flag's completion strobe. The bench provokes it by raising tx_fin in the same clock that the host writes the transmit start bit. It then judges the result in the next cycle: tx_go must still be 1, and only a later tx_fin may clear it. A second overlap, rx_fin arriving while reception is not armed, is judged by reading the count registers and finding them unchanged.

// File: rtl/pktmem_pkg.sv
package pktmem_pkg;

  // Host register offsets
  typedef enum logic [2:0] {
    OFS_PTR_LO = 3'd0,
    OFS_PTR_HI = 3'd1,
    OFS_MODE   = 3'd2,
    OFS_STAT   = 3'd3,
    OFS_DATA   = 3'd4
  } reg_ofs_e;

  // Mode register bit positions
  localparam int unsigned MB_DMA = 7;
  localparam int unsigned MB_RX  = 6;
  localparam int unsigned MB_TX  = 5;
  localparam int unsigned MB_MUX = 0;

  // Status register bit positions
  localparam int unsigned SB_RX  = 5;
  localparam int unsigned SB_TX  = 4;
  localparam int unsigned SB_DMA = 3;

  // Decoded command request carried from a mode write
  typedef struct packed {
    logic dma;
    logic rx;
    logic tx;
    logic mux;
  } cmd_req_t;

  function automatic logic [7:0] mode_image(input logic dma, input logic rx,
                                            input logic tx, input logic mux);
    logic [7:0] m;
    m         = 8'h00;
    m[MB_DMA] = dma;
    m[MB_RX]  = rx;
    m[MB_TX]  = tx;
    m[MB_MUX] = mux;
    return m;
  endfunction

  function automatic logic [7:0] stat_image(input logic rx, input logic tx,
                                            input logic dma);
    logic [7:0] s;
    s         = 8'h00;
    s[SB_RX]  = rx;
    s[SB_TX]  = tx;
    s[SB_DMA] = dma;
    return s;
  endfunction

endpackage

// File: rtl/pktmem_buf.sv
module pktmem_buf #(
  parameter int unsigned DEPTH = 2048,
  parameter int unsigned AW    = $clog2(DEPTH),
  parameter int unsigned NRD   = 1
) (
  input  logic                     clk,
  input  logic                     we,
  input  logic [AW-1:0]            waddr,
  input  logic [7:0]               wdata,
  input  logic [NRD-1:0][AW-1:0]   raddr,
  output logic [NRD-1:0][7:0]      rdata
);

  logic [7:0] mem [DEPTH];

  always_ff @(posedge clk) begin
    if (we) mem[waddr] <= wdata;
  end

  // One asynchronous read port per consumer
  for (genvar g = 0; g < int'(NRD); g++) begin : g_rd
    assign rdata[g] = mem[raddr[g]];
  end

endmodule

// File: rtl/pktmem_ptr.sv
module pktmem_ptr #(
  parameter int unsigned DEPTH = 2048,
  parameter int unsigned AW    = $clog2(DEPTH)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          ld_lo,
  input  logic          ld_hi,
  input  logic [7:0]    wbyte,
  input  logic          adv,
  output logic [AW-1:0] ptr
);

  localparam int unsigned HI_W = AW - 8;

  // Next address after an access, wrapping at the buffer end
  function automatic logic [AW-1:0] ptr_step(input logic [AW-1:0] p);
    if (p == AW'(DEPTH - 1)) return '0;
    return p + 1'b1;
  endfunction

  logic [AW-1:0] ptr_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      ptr_q <= '0;
    end else if (ld_lo) begin
      ptr_q[7:0] <= wbyte;
    end else if (ld_hi) begin
      ptr_q[AW-1:8] <= wbyte[HI_W-1:0];
    end else if (adv) begin
      ptr_q <= ptr_step(ptr_q);
    end
  end

  assign ptr = ptr_q;

endmodule

// File: rtl/pktmem_cmd.sv
module pktmem_cmd
  import pktmem_pkg::*;
(
  input  logic     clk,
  input  logic     rst_n,
  input  logic     mode_wr,
  input  cmd_req_t req,
  input  logic     tx_fin,
  input  logic     rx_fin,
  input  logic     dma_fin,
  input  logic     dma_abort,
  output logic     tx_busy,
  output logic     rx_armed,
  output logic     dma_busy,
  output logic     mux_rx
);

  localparam int unsigned NCMD = 3;

  logic [NCMD-1:0] set_v;
  logic [NCMD-1:0] clr_v;
  logic [NCMD-1:0] busy_v;
  logic            mux_q;

  // index 0: transmit, 1: receive arm, 2: DMA
  assign set_v = {NCMD{mode_wr}} & {req.dma, req.rx, req.tx};
  assign clr_v = {dma_fin | dma_abort, rx_fin, tx_fin};

  for (genvar gi = 0; gi < int'(NCMD); gi++) begin : g_flag
    logic q;
    always_ff @(posedge clk) begin
      if (!rst_n)          q <= 1'b0;
      else if (set_v[gi])  q <= 1'b1;
      else if (clr_v[gi])  q <= 1'b0;
    end
    assign busy_v[gi] = q;
  end

  always_ff @(posedge clk) begin
    if (!rst_n)       mux_q <= 1'b0;
    else if (mode_wr) mux_q <= req.mux;
  end

  assign tx_busy  = busy_v[0];
  assign rx_armed = busy_v[1];
  assign dma_busy = busy_v[2];
  assign mux_rx   = mux_q;

endmodule

// File: rtl/pktmem_ctrl.sv
module pktmem_ctrl
  import pktmem_pkg::*;
#(
  parameter  int unsigned BUF_BYTES = 2048,
  localparam int unsigned AW        = $clog2(BUF_BYTES),
  localparam int unsigned CW        = $clog2(BUF_BYTES + 1)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic [2:0]    host_addr,
  input  logic          host_wr,
  input  logic          host_rd,
  input  logic [7:0]    host_wdata,
  output logic [7:0]    host_rdata,
  output logic          tx_go,
  input  logic          tx_fin,
  input  logic [AW-1:0] tx_rd_addr,
  output logic [7:0]    tx_rd_data,
  output logic          rx_open,
  input  logic          rx_wr,
  input  logic [AW-1:0] rx_wr_addr,
  input  logic [7:0]    rx_wr_data,
  input  logic          rx_fin,
  input  logic [CW-1:0] rx_len,
  output logic          dma_go,
  input  logic          dma_fin
);

  // Named internal events
  logic          acc_data;
  logic          host_data_wr;
  logic          ld_lo;
  logic          ld_hi;
  logic          mode_wr;
  logic          dma_abort;
  logic          tx_req;
  logic          rx_req;
  logic          mux_rx;
  logic          rx_take;
  logic          net_rx_ok;
  logic          host_rx_wr;
  logic [AW-1:0] host_ptr;
  logic [CW-1:0] rx_count;
  logic [15:0]   cnt16;
  cmd_req_t      req;

  assign acc_data     = (host_wr | host_rd) && (host_addr == OFS_DATA);
  assign host_data_wr = host_wr && (host_addr == OFS_DATA);
  assign ld_lo        = host_wr && (host_addr == OFS_PTR_LO);
  assign ld_hi        = host_wr && (host_addr == OFS_PTR_HI);
  assign mode_wr      = host_wr && (host_addr == OFS_MODE);
  assign dma_abort    = host_wr && (host_addr == OFS_STAT);

  assign req.dma = host_wdata[MB_DMA];
  assign req.rx  = host_wdata[MB_RX];
  assign req.tx  = host_wdata[MB_TX];
  assign req.mux = host_wdata[MB_MUX];
  assign tx_req  = mode_wr & req.tx;
  assign rx_req  = mode_wr & req.rx;

  pktmem_ptr #(.DEPTH(BUF_BYTES), .AW(AW)) u_ptr (
    .clk   (clk),
    .rst_n (rst_n),
    .ld_lo (ld_lo),
    .ld_hi (ld_hi),
    .wbyte (host_wdata),
    .adv   (acc_data),
    .ptr   (host_ptr)
  );

  pktmem_cmd u_cmd (
    .clk       (clk),
    .rst_n     (rst_n),
    .mode_wr   (mode_wr),
    .req       (req),
    .tx_fin    (tx_fin),
    .rx_fin    (rx_fin),
    .dma_fin   (dma_fin),
    .dma_abort (dma_abort),
    .tx_busy   (tx_go),
    .rx_armed  (rx_open),
    .dma_busy  (dma_go),
    .mux_rx    (mux_rx)
  );

  // Transmit buffer: host writes when it faces the host; two read ports
  logic [1:0][AW-1:0] tx_raddr;
  logic [1:0][7:0]    tx_rdat;
  assign tx_raddr[0] = host_ptr;
  assign tx_raddr[1] = tx_rd_addr;

  pktmem_buf #(.DEPTH(BUF_BYTES), .AW(AW), .NRD(2)) u_txbuf (
    .clk   (clk),
    .we    (host_data_wr & ~mux_rx),
    .waddr (host_ptr),
    .wdata (host_wdata),
    .raddr (tx_raddr),
    .rdata (tx_rdat)
  );

  assign tx_rd_data = tx_rdat[1];

  // Receive buffer: host side when muxed in, network side when armed
  assign host_rx_wr = host_data_wr & mux_rx;
  assign net_rx_ok  = rx_wr & rx_open & ~mux_rx;

  logic [0:0][AW-1:0] rx_raddr;
  logic [0:0][7:0]    rx_rdat;
  logic [AW-1:0]      rx_waddr;
  logic [7:0]         rx_wdat;
  assign rx_raddr[0] = host_ptr;
  assign rx_waddr    = host_rx_wr ? host_ptr   : rx_wr_addr;
  assign rx_wdat     = host_rx_wr ? host_wdata : rx_wr_data;

  pktmem_buf #(.DEPTH(BUF_BYTES), .AW(AW), .NRD(1)) u_rxbuf (
    .clk   (clk),
    .we    (host_rx_wr | net_rx_ok),
    .waddr (rx_waddr),
    .wdata (rx_wdat),
    .raddr (rx_raddr),
    .rdata (rx_rdat)
  );

  // Received byte count, latched only when reception was armed
  assign rx_take = rx_fin & rx_open;

  always_ff @(posedge clk) begin
    if (!rst_n)       rx_count <= '0;
    else if (rx_take) rx_count <= rx_len;
  end

  assign cnt16 = 16'(rx_count);

  always_comb begin
    case (host_addr)
      OFS_PTR_LO: host_rdata = cnt16[7:0];
      OFS_PTR_HI: host_rdata = cnt16[15:8];
      OFS_MODE:   host_rdata = mode_image(dma_go, rx_open, tx_go, mux_rx);
      OFS_STAT:   host_rdata = stat_image(rx_open, tx_go, dma_go);
      OFS_DATA:   host_rdata = mux_rx ? rx_rdat[0] : tx_rdat[0];
      default:    host_rdata = 8'h00;
    endcase
  end

endmodule

// File: rtl/pktmem_ctrl_chk.sv
module pktmem_ctrl_chk
  import pktmem_pkg::*;
#(
  parameter  int unsigned BUF_BYTES = 2048,
  localparam int unsigned AW        = $clog2(BUF_BYTES),
  localparam int unsigned CW        = $clog2(BUF_BYTES + 1)
) (
  input logic          clk,
  input logic          rst_n,
  input logic          acc_data,
  input logic [AW-1:0] host_ptr,
  input logic          mode_wr,
  input logic          tx_req,
  input logic          rx_req,
  input logic          tx_fin,
  input logic          tx_go,
  input logic          rx_fin,
  input logic          rx_open,
  input logic [CW-1:0] rx_len,
  input logic [CW-1:0] rx_count,
  input logic          dma_abort,
  input logic          dma_go,
  input logic [2:0]    host_addr,
  input logic [7:0]    host_rdata
);

  localparam logic [AW-1:0] LAST = AW'(BUF_BYTES - 1);

  AST_PTR_WRAP: assert property (@(posedge clk) disable iff (!rst_n)
    acc_data && host_ptr == LAST |=> host_ptr == '0); // R3

  AST_PTR_STEP: assert property (@(posedge clk) disable iff (!rst_n)
    acc_data && host_ptr != LAST |=> host_ptr == $past(host_ptr) + 1'b1); // R3

  AST_TX_SET: assert property (@(posedge clk) disable iff (!rst_n)
    tx_req |=> tx_go); // R13

  AST_TX_DONE: assert property (@(posedge clk) disable iff (!rst_n)
    tx_fin && !tx_req |=> !tx_go); // R5

  AST_RX_LATCH: assert property (@(posedge clk) disable iff (!rst_n)
    rx_fin && rx_open && !rx_req |=> !rx_open && rx_count == $past(rx_len)); // R6

  AST_RX_IGNORED: assert property (@(posedge clk) disable iff (!rst_n)
    rx_fin && !rx_open |=> $stable(rx_count)); // R6

  AST_DMA_ABORT: assert property (@(posedge clk) disable iff (!rst_n)
    dma_abort |=> !dma_go); // R7

  AST_ZERO_KEEPS: assert property (@(posedge clk) disable iff (!rst_n)
    mode_wr && !tx_req && !tx_fin && tx_go |=> tx_go); // R8

  AST_STAT_MAP: assert property (@(posedge clk) disable iff (!rst_n)
    host_addr == OFS_STAT |-> host_rdata == stat_image(rx_open, tx_go, dma_go)); // R9

endmodule

bind pktmem_ctrl pktmem_ctrl_chk #(.BUF_BYTES(BUF_BYTES)) u_chk (
  .clk        (clk),
  .rst_n      (rst_n),
  .acc_data   (acc_data),
  .host_ptr   (host_ptr),
  .mode_wr    (mode_wr),
  .tx_req     (tx_req),
  .rx_req     (rx_req),
  .tx_fin     (tx_fin),
  .tx_go      (tx_go),
  .rx_fin     (rx_fin),
  .rx_open    (rx_open),
  .rx_len     (rx_len),
  .rx_count   (rx_count),
  .dma_abort  (dma_abort),
  .dma_go     (dma_go),
  .host_addr  (host_addr),
  .host_rdata (host_rdata)
);

// File: tb/pktmem_ctrl_tb.sv
module pktmem_ctrl_tb;

  localparam int CLK_PERIOD = 10;
  localparam int AW = 11;
  localparam int CW = 12;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic [2:0]    host_addr = '0;
  logic          host_wr = 1'b0;
  logic          host_rd = 1'b0;
  logic [7:0]    host_wdata = '0;
  logic [7:0]    host_rdata;
  logic          tx_go;
  logic          tx_fin = 1'b0;
  logic [AW-1:0] tx_rd_addr = '0;
  logic [7:0]    tx_rd_data;
  logic          rx_open;
  logic          rx_wr = 1'b0;
  logic [AW-1:0] rx_wr_addr = '0;
  logic [7:0]    rx_wr_data = '0;
  logic          rx_fin = 1'b0;
  logic [CW-1:0] rx_len = '0;
  logic          dma_go;
  logic          dma_fin = 1'b0;

  int n_chk = 0;
  int n_fail = 0;
  bit finished = 1'b0;

  always #(CLK_PERIOD/2) clk = ~clk;

  pktmem_ctrl u_dut (
    .clk(clk), .rst_n(rst_n), .host_addr(host_addr), .host_wr(host_wr),
    .host_rd(host_rd), .host_wdata(host_wdata), .host_rdata(host_rdata),
    .tx_go(tx_go), .tx_fin(tx_fin), .tx_rd_addr(tx_rd_addr),
    .tx_rd_data(tx_rd_data), .rx_open(rx_open), .rx_wr(rx_wr),
    .rx_wr_addr(rx_wr_addr), .rx_wr_data(rx_wr_data), .rx_fin(rx_fin),
    .rx_len(rx_len), .dma_go(dma_go), .dma_fin(dma_fin)
  );

  // {pointer, data} pairs
  localparam logic [18:0] VEC [8] = '{
    {11'd0,    8'h3C}, {11'd1,    8'hC3}, {11'd255,  8'h5A}, {11'd256,  8'hA5},
    {11'd1023, 8'h0F}, {11'd1500, 8'hF0}, {11'd2040, 8'h81}, {11'd2046, 8'h7E}
  };

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [2:0] a, input logic [7:0] d);
    @(negedge clk);
    host_addr = a; host_wdata = d; host_wr = 1'b1;
    @(negedge clk);
    host_wr = 1'b0;
  endtask

  task automatic rd(input logic [2:0] a, output logic [7:0] d);
    @(negedge clk);
    host_addr = a; host_rd = 1'b1;
    #1 d = host_rdata;
    @(negedge clk);
    host_rd = 1'b0;
  endtask

  task automatic set_ptr(input logic [10:0] p);
    wr(3'd0, p[7:0]);
    wr(3'd1, {5'd0, p[10:8]});
  endtask

  task automatic net_write(input logic [10:0] a, input logic [7:0] d);
    @(negedge clk);
    rx_wr = 1'b1; rx_wr_addr = a; rx_wr_data = d;
    @(negedge clk);
    rx_wr = 1'b0;
  endtask

  task automatic pulse_tx();
    @(negedge clk); tx_fin = 1'b1;
    @(negedge clk); tx_fin = 1'b0;
  endtask

  task automatic pulse_rx(input logic [11:0] len);
    @(negedge clk); rx_fin = 1'b1; rx_len = len;
    @(negedge clk); rx_fin = 1'b0;
  endtask

  task automatic pulse_dma();
    @(negedge clk); dma_fin = 1'b1;
    @(negedge clk); dma_fin = 1'b0;
  endtask

  task automatic tx_peek(input logic [10:0] a, output logic [7:0] d);
    @(negedge clk);
    tx_rd_addr = a;
    #1 d = tx_rd_data;
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!finished) begin
      n_chk++; n_fail++;
      $display("FAIL watchdog: actual hung expected done");
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
    end
  end

  initial begin
    logic [7:0] v;
    logic [7:0] v2;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;

    // R1 reset state
    rd(3'd3, v); check("R1 status", v, 8'h00);
    rd(3'd2, v); check("R1 mode", v, 8'h00);
    rd(3'd0, v); check("R1 count lo", v, 8'h00);
    rd(3'd1, v); check("R1 count hi", v, 8'h00);
    check("R1 flags", {tx_go, rx_open, dma_go}, 3'b000);
    wr(3'd4, 8'hA5);
    tx_peek(11'd0, v); check("R1 pointer at 0, tx buffer faces host", v, 8'hA5);

    // R2 / R12 table walk: write through host, read via network and host
    foreach (VEC[i]) begin
      set_ptr(VEC[i][18:8]);
      wr(3'd4, VEC[i][7:0]);
    end
    foreach (VEC[i]) begin
      tx_peek(VEC[i][18:8], v);
      check("R12 network tx read", v, 32'(VEC[i][7:0]));
      set_ptr(VEC[i][18:8]);
      rd(3'd4, v);
      check("R2 host data read", v, 32'(VEC[i][7:0]));
    end

    // R3 consecutive reads and wrap at buffer end
    set_ptr(11'd255);
    rd(3'd4, v); rd(3'd4, v2);
    check("R3 step read 1", v, 8'h5A);
    check("R3 step read 2", v2, 8'hA5);
    set_ptr(11'd2047);
    wr(3'd4, 8'h11); wr(3'd4, 8'h22);
    tx_peek(11'd2047, v); check("R3 last byte", v, 8'h11);
    tx_peek(11'd0, v);    check("R3 wrap to 0", v, 8'h22);

    // R10 count reads do not move the pointer
    set_ptr(11'd1);
    rd(3'd0, v); rd(3'd1, v);
    rd(3'd4, v); check("R10 pointer unmoved by count read", v, 8'hC3);

    // R4 mux selects host-facing buffer
    wr(3'd2, 8'h00); set_ptr(11'd10); wr(3'd4, 8'h11);
    wr(3'd2, 8'h01); set_ptr(11'd10); wr(3'd4, 8'h77);
    tx_peek(11'd10, v); check("R4 tx buffer untouched", v, 8'h11);
    set_ptr(11'd10); rd(3'd4, v); check("R4 rx buffer via host", v, 8'h77);
    wr(3'd2, 8'h00); set_ptr(11'd10); rd(3'd4, v); check("R4 tx buffer via host", v, 8'h11);

    // R8 page bits ignored
    wr(3'd2, 8'h1F); rd(3'd2, v); check("R8 page bits read 0", v, 8'h01);

    // R5 transmit flag
    wr(3'd2, 8'h20);
    check("R5 tx_go set", tx_go, 1'b1);
    repeat (3) @(negedge clk);
    check("R5 tx_go holds", tx_go, 1'b1);
    wr(3'd2, 8'h00);
    check("R8 zero write keeps tx_go", tx_go, 1'b1);
    pulse_tx();
    check("R5 tx_go cleared", tx_go, 1'b0);

    // R13 set and completion in the same cycle
    wr(3'd2, 8'h20);
    @(negedge clk);
    host_addr = 3'd2; host_wdata = 8'h20; host_wr = 1'b1; tx_fin = 1'b1;
    @(negedge clk);
    host_wr = 1'b0; tx_fin = 1'b0;
    check("R13 set wins over tx_fin", tx_go, 1'b1);
    pulse_tx();
    check("R13 later fin clears", tx_go, 1'b0);

    // R6 / R11 receive
    wr(3'd2, 8'h40);
    check("R6 rx_open set", rx_open, 1'b1);
    net_write(11'd3, 8'h5A);
    pulse_rx(12'd1234);
    check("R6 rx_open cleared", rx_open, 1'b0);
    rd(3'd0, v); check("R6 count lo", v, 8'hD2);
    rd(3'd1, v); check("R6 count hi", v, 8'h04);
    net_write(11'd3, 8'hFF);
    pulse_rx(12'd99);
    rd(3'd0, v); check("R6 unarmed fin ignored", v, 8'hD2);
    wr(3'd2, 8'h01); set_ptr(11'd3); rd(3'd4, v);
    check("R11 armed write kept, unarmed dropped", v, 8'h5A);
    set_ptr(11'd4); wr(3'd4, 8'h12);
    wr(3'd2, 8'h41);
    net_write(11'd4, 8'hEE);
    set_ptr(11'd4); rd(3'd4, v);
    check("R11 write ignored while rx buffer on host", v, 8'h12);
    pulse_rx(12'd7);

    // R7 DMA flag
    wr(3'd2, 8'h80);
    check("R7 dma_go set", dma_go, 1'b1);
    pulse_dma();
    check("R7 dma_fin clears", dma_go, 1'b0);
    wr(3'd2, 8'h80);
    wr(3'd3, 8'h00);
    check("R7 abort clears", dma_go, 1'b0);

    // R9 status and mode images
    wr(3'd2, 8'hE1);
    rd(3'd3, v); check("R9 status image", v, 8'h38);
    rd(3'd2, v); check("R9 mode image", v, 8'hE1);
    pulse_tx(); pulse_rx(12'd5); pulse_dma();
    rd(3'd3, v); check("R9 status clear", v, 8'h00);

    finished = 1'b1;
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

endmodule